// File: doc/BRIEF.md
# Synchronous Card Command Front End

This block sits between the contact pins of a synchronous memory card and the card's storage logic. It watches a card clock, a card reset and an open-drain data line. The pins are sampled by the chip's own system clock, and edges are found after a short synchronizer. The block collects a 24-bit command frame from the data line. It decodes the frame into one of seven operations and then runs one of two modes. In streaming mode it pulls bytes from storage and shifts them out one bit per card clock. In busy mode it hands one request to storage and holds the data line low until storage reports that the work is finished.

The storage arrays, the programming timer and the code comparison all live outside the block. Two handshakes connect the block to that logic.

The fetch port is the stream source. The block raises `fetch_valid` with a stable `fetch_space` and `fetch_addr`. Storage accepts by raising `fetch_ready`, and `fetch_data` must be valid in that same cycle. Storage may hold `fetch_ready` low to stall, but it must accept before the card falling edge that needs the byte.

The request port carries writes and compares. `op_valid` stays high with a stable payload until `op_ready` is seen. `op_done` is a one-cycle pulse that storage gives after acceptance.

A card reset edge is the only exception to both handshakes: it withdraws any pending request.

Top module: `sc_cmd_front`

## Requirements
- R1: After `rst_n` is released, the data line is released (`io_oe`=0), and `op_valid` and `fetch_valid` are low.
- R2: While card reset is low, each card clock rising edge shifts one bit of the data line into the frame. A frame is 24 bits: a control byte, then an address byte, then a data byte, each byte sent bit 0 first. The line stays released during frame entry. Address and data bytes appear unchanged on `op_addr` and `op_data`.
- R3: The control codes 0x38, 0x3C, 0x39 and 0x33 each raise a storage request. Their `op_kind` values are 0 (main update), 1 (protection-bit write), 2 (code-store update) and 3 (code compare).
- R4: Any other control code, apart from the three read codes, returns the block to frame entry. It raises no request, raises no fetch and leaves the line released. The next frame is decoded normally.
- R5: Control 0x30 with address N streams main-array bytes N, N+1 and so on, each byte bit 0 first, fetched with `fetch_space`=0. The falling edge that ends the 24th frame clock changes nothing. Each later falling edge drives the next bit.
- R6: A main read streams exactly (2^ADDR_W − N)×8 bits. The next falling edge releases the line and returns to frame entry, so the read takes (2^ADDR_W − N)×8 + 1 clocks after the frame.
- R7: Control 0x34 streams PROT_BYTES bytes from `fetch_space`=1, and control 0x31 streams SEC_BYTES bytes from `fetch_space`=2. Both start at address 0, ignore the address byte, and use the same release rule as R6.
- R8: In busy mode, each falling edge after the one that ends the frame pulls the line low until completion is known.
- R9: The first falling edge that occurs at or after the `op_done` pulse releases the line and returns to frame entry. An `op_done` in the same system cycle as the edge counts. An `op_done` one cycle after the edge waits for the next falling edge.
- R10: `op_valid` holds with a stable payload until `op_ready`, and it is raised once per accepted command.
- R11: A rising card reset edge aborts any mode. The line is released, `op_valid` and `fetch_valid` drop, and frame entry restarts once reset is low.
- R12: Card clock edges seen while card reset is high shift nothing into the frame.
- R13: `fetch_valid` holds with a stable space and address until `fetch_ready`. Storage must accept before the falling edge that needs the byte, and the streamed bits then match storage content under stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| card_clk | input | 1 | Card clock pin (low at reset) |
| card_rst | input | 1 | Card reset pin |
| io_in | input | 1 | Data line as seen on the pin |
| io_out | output | 1 | Value driven on the data line when enabled (always low while enabled) |
| io_oe | output | 1 | Drive enable of the open-drain data line |
| fetch_valid | output | 1 | Byte fetch request valid |
| fetch_ready | input | 1 | Storage accepts the fetch; data valid this cycle |
| fetch_space | output | 2 | 0 main array, 1 protection bits, 2 code store |
| fetch_addr | output | ADDR_W | Byte address of the fetch |
| fetch_data | input | 8 | Fetched byte |
| op_valid | output | 1 | Storage request valid |
| op_ready | input | 1 | Storage accepts the request |
| op_kind | output | 2 | Request kind, encoded as in R3 |
| op_addr | output | 8 | Address byte of the frame |
| op_data | output | 8 | Data byte of the frame |
| op_done | input | 1 | One-cycle pulse: storage finished the accepted request |

## Verification
Two events can land in the same system cycle: storage's completion pulse and the detected falling card-clock edge that decides the line level in busy mode. The bench places `op_done` one cycle before the detected edge, in the same cycle, and one cycle after it. It then reads the line just before the next rising edge. The first two placements must show a released line on that edge. The third must still show low, with release on the following edge. Main-array reads from every start address of a small array also run against a fetch port that stalls on a fixed pattern, so that byte fetches and bit shifts meet at byte boundaries.

// File: rtl/scf_pkg.sv
package scf_pkg;
  typedef enum logic [1:0] {
    FS_CMD  = 2'd0,
    FS_OUT  = 2'd1,
    FS_PROC = 2'd2
  } fsm_t;

  typedef enum logic [1:0] {
    SP_MAIN = 2'd0,
    SP_PROT = 2'd1,
    SP_SEC  = 2'd2
  } space_t;

  typedef enum logic [1:0] {
    OP_UPD_MAIN = 2'd0,
    OP_WR_PROT  = 2'd1,
    OP_UPD_SEC  = 2'd2,
    OP_CMP      = 2'd3
  } op_t;

  localparam logic [7:0] CC_RD_MAIN  = 8'h30;
  localparam logic [7:0] CC_UPD_MAIN = 8'h38;
  localparam logic [7:0] CC_RD_PROT  = 8'h34;
  localparam logic [7:0] CC_WR_PROT  = 8'h3C;
  localparam logic [7:0] CC_RD_SEC   = 8'h31;
  localparam logic [7:0] CC_UPD_SEC  = 8'h39;
  localparam logic [7:0] CC_CMP      = 8'h33;

  localparam int FRAME_BITS = 24;

  typedef struct packed {
    logic   valid;
    logic   is_read;
    space_t space;
    op_t    op;
  } dec_t;
endpackage

// File: rtl/scf_pin_sync.sv
module scf_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_clk,
  input  logic pin_rst,
  input  logic pin_dat,
  output logic clk_rise,
  output logic clk_fall,
  output logic rst_rise,
  output logic rst_lvl,
  output logic dat
);
  logic [STAGES-1:0][2:0] chain_q;
  logic [1:0]             prev_q;
  logic [2:0]             tail;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {pin_dat, pin_rst, pin_clk};
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], {pin_dat, pin_rst, pin_clk}};
      end
    end
  endgenerate

  assign tail = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= tail[1:0];
  end

  assign clk_rise = tail[0] & ~prev_q[0];
  assign clk_fall = ~tail[0] & prev_q[0];
  assign rst_rise = tail[1] & ~prev_q[1];
  assign rst_lvl  = tail[1];
  assign dat      = tail[2];
endmodule

// File: rtl/scf_cmd_rx.sv
module scf_cmd_rx
  import scf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       rise,
  input  logic       hold_clear,
  input  logic       dat,
  output logic       frame_done,
  output logic [7:0] ctrl,
  output logic [7:0] addr,
  output logic [7:0] data
);
  localparam int CW = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] sr_q;
  logic [CW-1:0]         cnt_q;
  logic                  done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (hold_clear) begin
        cnt_q <= '0;
      end else if (enable && rise) begin
        sr_q <= {dat, sr_q[FRAME_BITS-1:1]};
        if (cnt_q == CW'(FRAME_BITS - 1)) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign frame_done = done_q;
  assign ctrl       = sr_q[7:0];
  assign addr       = sr_q[15:8];
  assign data       = sr_q[23:16];
endmodule

// File: rtl/scf_cmd_dec.sv
module scf_cmd_dec
  import scf_pkg::*;
(
  input  logic [7:0] ctrl,
  output dec_t       dec
);
  always_comb begin
    dec.valid   = 1'b1;
    dec.is_read = 1'b0;
    dec.space   = SP_MAIN;
    dec.op      = OP_UPD_MAIN;
    case (ctrl)
      CC_RD_MAIN:  dec.is_read = 1'b1;
      CC_RD_PROT:  begin dec.is_read = 1'b1; dec.space = SP_PROT; end
      CC_RD_SEC:   begin dec.is_read = 1'b1; dec.space = SP_SEC;  end
      CC_UPD_MAIN: dec.op = OP_UPD_MAIN;
      CC_WR_PROT:  dec.op = OP_WR_PROT;
      CC_UPD_SEC:  dec.op = OP_UPD_SEC;
      CC_CMP:      dec.op = OP_CMP;
      default:     dec.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/scf_out_seq.sv
module scf_out_seq
  import scf_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PROT_BYTES = 4,
  parameter int SEC_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  space_t            start_space,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              abort,
  input  logic              step,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output space_t            fetch_space,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [7:0]        fetch_data,
  output logic              more,
  output logic              cur_bit,
  output logic              have
);
  localparam int BW = ADDR_W + 1;
  localparam logic [BW-1:0] MAIN_TOTAL = BW'(2 ** ADDR_W);
  localparam logic [BW-1:0] PROT_TOTAL = BW'(PROT_BYTES);
  localparam logic [BW-1:0] SEC_TOTAL  = BW'(SEC_BYTES);

  logic [BW-1:0]     left_q;
  logic [ADDR_W-1:0] addr_q;
  space_t            space_q;
  logic [2:0]        bidx_q;
  logic              have_q;
  logic [7:0]        byte_q;
  logic [BW-1:0]     first_len;

  always_comb begin
    case (start_space)
      SP_PROT: first_len = PROT_TOTAL;
      SP_SEC:  first_len = SEC_TOTAL;
      default: first_len = MAIN_TOTAL - {1'b0, start_addr};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      addr_q  <= '0;
      space_q <= SP_MAIN;
      bidx_q  <= '0;
      have_q  <= 1'b0;
      byte_q  <= '0;
    end else if (abort) begin
      left_q <= '0;
      have_q <= 1'b0;
      bidx_q <= '0;
    end else if (start) begin
      left_q  <= first_len;
      addr_q  <= (start_space == SP_MAIN) ? start_addr : '0;
      space_q <= start_space;
      bidx_q  <= '0;
      have_q  <= 1'b0;
    end else begin
      if (fetch_valid && fetch_ready) begin
        byte_q <= fetch_data;
        have_q <= 1'b1;
      end
      if (step && more) begin
        bidx_q <= bidx_q + 3'd1;
        if (bidx_q == 3'd7) begin
          have_q <= 1'b0;
          addr_q <= addr_q + 1'b1;
          left_q <= left_q - 1'b1;
        end
      end
    end
  end

  assign more        = (left_q != '0);
  assign fetch_valid = more && !have_q;
  assign fetch_space = space_q;
  assign fetch_addr  = addr_q;
  assign cur_bit     = byte_q[bidx_q];
  assign have        = have_q;
endmodule

// File: rtl/sc_cmd_front.sv
module sc_cmd_front
  import scf_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PROT_BYTES  = 4,
  parameter int SEC_BYTES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_clk,
  input  logic              card_rst,
  input  logic              io_in,
  output logic              io_out,
  output logic              io_oe,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [1:0]        fetch_space,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [7:0]        fetch_data,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [1:0]        op_kind,
  output logic [7:0]        op_addr,
  output logic [7:0]        op_data,
  input  logic              op_done
);
  logic clk_rise, clk_fall, rst_rise, rst_lvl, dat_s;
  logic frame_done;
  logic [7:0] f_ctrl, f_addr, f_data;
  dec_t dec;
  fsm_t st_q;
  logic lead_q, line_q, opv_q, done_seen_q;
  op_t  opk_q;
  logic [7:0] opa_q, opd_q;
  logic seq_start, seq_step, seq_more, seq_bit, seq_have;
  space_t seq_space;
  logic done_now;

  scf_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_clk(card_clk), .pin_rst(card_rst), .pin_dat(io_in),
    .clk_rise(clk_rise), .clk_fall(clk_fall),
    .rst_rise(rst_rise), .rst_lvl(rst_lvl), .dat(dat_s)
  );

  scf_cmd_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .enable(st_q == FS_CMD), .rise(clk_rise), .hold_clear(rst_lvl),
    .dat(dat_s), .frame_done(frame_done),
    .ctrl(f_ctrl), .addr(f_addr), .data(f_data)
  );

  scf_cmd_dec u_dec (.ctrl(f_ctrl), .dec(dec));

  assign seq_start = (st_q == FS_CMD) && frame_done && dec.valid && dec.is_read;
  assign seq_step  = (st_q == FS_OUT) && clk_fall && !lead_q;

  scf_out_seq #(
    .ADDR_W(ADDR_W), .PROT_BYTES(PROT_BYTES), .SEC_BYTES(SEC_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(seq_start), .start_space(dec.space), .start_addr(f_addr[ADDR_W-1:0]),
    .abort(rst_rise), .step(seq_step),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_space(seq_space), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
    .more(seq_more), .cur_bit(seq_bit), .have(seq_have)
  );

  assign done_now = op_done && !opv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= FS_CMD;
      lead_q      <= 1'b0;
      line_q      <= 1'b1;
      opv_q       <= 1'b0;
      done_seen_q <= 1'b0;
      opk_q       <= OP_UPD_MAIN;
      opa_q       <= '0;
      opd_q       <= '0;
    end else if (rst_rise) begin
      st_q   <= FS_CMD;
      lead_q <= 1'b0;
      line_q <= 1'b1;
      opv_q  <= 1'b0;
    end else begin
      case (st_q)
        FS_CMD: begin
          if (frame_done && dec.valid) begin
            lead_q <= 1'b1;
            if (dec.is_read) begin
              st_q <= FS_OUT;
            end else begin
              st_q        <= FS_PROC;
              opv_q       <= 1'b1;
              opk_q       <= dec.op;
              opa_q       <= f_addr;
              opd_q       <= f_data;
              done_seen_q <= 1'b0;
            end
          end
        end
        FS_OUT: begin
          if (clk_fall) begin
            if (lead_q)        lead_q <= 1'b0;
            else if (seq_more) line_q <= seq_bit;
            else begin
              line_q <= 1'b1;
              st_q   <= FS_CMD;
            end
          end
        end
        FS_PROC: begin
          if (opv_q && op_ready) opv_q <= 1'b0;
          if (done_now) done_seen_q <= 1'b1;
          if (clk_fall) begin
            if (lead_q) lead_q <= 1'b0;
            else if (done_seen_q || done_now) begin
              line_q <= 1'b1;
              st_q   <= FS_CMD;
            end else begin
              line_q <= 1'b0;
            end
          end
        end
        default: st_q <= FS_CMD;
      endcase
    end
  end

  assign io_out      = line_q;
  assign io_oe       = ~line_q;
  assign fetch_space = seq_space;
  assign op_valid    = opv_q;
  assign op_kind     = opk_q;
  assign op_addr     = opa_q;
  assign op_data     = opd_q;
endmodule

// File: rtl/scf_checks.sv
module scf_checks
  import scf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input fsm_t              st,
  input logic              lead,
  input logic              fall,
  input logic              rst_rise,
  input logic              more,
  input logic              have,
  input logic              done_seen,
  input logic              io_oe,
  input logic              op_valid,
  input logic              op_ready,
  input logic [1:0]        op_kind,
  input logic [7:0]        op_addr,
  input logic [7:0]        op_data,
  input logic              op_done,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [1:0]        fetch_space,
  input logic [ADDR_W-1:0] fetch_addr
);
  // R4, R1: frame entry keeps every output quiet
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st == FS_CMD |-> !op_valid && !fetch_valid && !io_oe);

  a_r10_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready && !rst_rise |=>
      op_valid && $stable(op_kind) && $stable(op_addr) && $stable(op_data));

  a_r13_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready && !rst_rise |=>
      fetch_valid && $stable(fetch_space) && $stable(fetch_addr));

  a_r13_byte_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    st == FS_OUT && fall && !lead && more |-> have);

  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    rst_rise |=> !io_oe && !op_valid && !fetch_valid);

  a_r8_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    st == FS_PROC && fall && !lead && !done_seen && !(op_done && !op_valid) && !rst_rise
      |=> io_oe);

  a_r9_done_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    st == FS_PROC && fall && !lead && op_done && !op_valid && !rst_rise
      |=> !io_oe && st == FS_CMD);
endmodule

bind sc_cmd_front scf_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .lead(lead_q), .fall(clk_fall),
  .rst_rise(rst_rise), .more(seq_more), .have(seq_have), .done_seen(done_seen_q),
  .io_oe(io_oe), .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
  .op_addr(op_addr), .op_data(op_data), .op_done(op_done),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .fetch_space(fetch_space), .fetch_addr(fetch_addr)
);

// File: tb/sim_sc_cmd_front.sv
module sim_sc_cmd_front;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic card_clk = 1'b0, card_rst = 1'b0, io_in = 1'b1;
  logic io_out, io_oe;
  logic fetch_valid, fetch_ready;
  logic [1:0] fetch_space;
  logic [AW-1:0] fetch_addr;
  logic [7:0] fetch_data;
  logic op_valid, op_ready = 1'b0, op_done = 1'b0;
  logic [1:0] op_kind;
  logic [7:0] op_addr, op_data;

  int errs = 0, checks = 0;
  logic seen_req = 1'b0;
  logic cmd_hi = 1'b1;
  logic [7:0] stall_q = 8'd0;

  wire line = io_oe ? io_out : 1'b1;

  function automatic logic [7:0] model(input int sp, input int a);
    int v;
    case (sp)
      0:       v = (a * 29 + 7) ^ 90;
      1:       v = 160 ^ (a * 2);
      default: v = 60 + a * 11;
    endcase
    return v[7:0];
  endfunction

  always @(posedge clk) stall_q <= stall_q + 8'd1;
  assign fetch_ready = fetch_valid && (stall_q[1:0] != 2'd0);
  assign fetch_data  = model(int'(fetch_space), int'(fetch_addr));

  sc_cmd_front #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .card_rst(card_rst),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_space(fetch_space), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
    .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .op_done(op_done)
  );

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  // one card clock pulse; done_at places op_done relative to the falling edge
  task automatic pulse(input logic b, input int done_at, output logic s);
    io_in = b;
    @(negedge clk);
    card_clk = 1'b1;
    repeat (HALF) begin
      @(negedge clk);
      seen_req = seen_req | op_valid | fetch_valid;
    end
    card_clk = 1'b0;
    for (int i = 1; i <= HALF; i++) begin
      @(negedge clk);
      op_done = (i == done_at);
      seen_req = seen_req | op_valid | fetch_valid;
    end
    op_done = 1'b0;
    s = line;
  endtask

  task automatic send_cmd(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d);
    logic [23:0] f;
    logic s;
    f = {d, a, c};
    cmd_hi = 1'b1;
    for (int i = 0; i < 24; i++) begin
      pulse(f[i], -1, s);
      if (s !== 1'b1) cmd_hi = 1'b0;
    end
  endtask

  task automatic stream(input logic [7:0] c, input logic [7:0] a, input int sp,
                        input int base, input int nbytes, output int bad, output logic rel);
    logic s;
    send_cmd(c, a, 8'h00);
    bad = 0;
    for (int k = 0; k < nbytes * 8; k++) begin
      logic [7:0] m;
      pulse(1'b1, -1, s);
      m = model(sp, base + k / 8);
      if (s !== m[k % 8]) bad++;
    end
    pulse(1'b1, -1, rel);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 180000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int bad;
    logic rel, s;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!io_oe && !op_valid && !fetch_valid, "R1 reset state",
        int'({io_oe, op_valid, fetch_valid}), 0);

    // R2 R3 R8 R9 R10: every request code, completion placed around the edge
    for (int t = 0; t < 4; t++) begin
      logic [7:0] c, a, d;
      logic [1:0] k;
      int dat;
      case (t)
        0:       begin c = 8'h38; k = 2'd0; dat = 1; end
        1:       begin c = 8'h3C; k = 2'd1; dat = 2; end
        2:       begin c = 8'h39; k = 2'd2; dat = 3; end
        default: begin c = 8'h33; k = 2'd3; dat = 2; end
      endcase
      a = 8'(8'h11 * (t + 1));
      d = 8'(8'hC3 ^ (t * 16));
      send_cmd(c, a, d);
      chk(cmd_hi, "R2 line released during frame", int'(cmd_hi), 1);
      chk(op_valid && op_kind == k && op_addr == a && op_data == d,
          "R2 R3 request payload", int'({op_valid, op_kind, op_addr, op_data}),
          int'({1'b1, k, a, d}));
      repeat (3) @(negedge clk);
      chk(op_valid && op_addr == a && op_data == d, "R10 request held", int'(op_valid), 1);
      op_ready = 1'b1;
      @(negedge clk);
      op_ready = 1'b0;
      @(negedge clk);
      chk(!op_valid, "R10 single request", int'(op_valid), 0);
      pulse(1'b1, -1, s);
      chk(s == 1'b0, "R8 busy low first edge", int'(s), 0);
      pulse(1'b1, -1, s);
      chk(s == 1'b0, "R8 busy low second edge", int'(s), 0);
      pulse(1'b1, dat, s);
      if (dat == 3) begin
        chk(s == 1'b0, "R9 done after edge keeps low", int'(s), 0);
        pulse(1'b1, -1, s);
        chk(s == 1'b1, "R9 release on following edge", int'(s), 1);
      end else begin
        chk(s == 1'b1, "R9 done at or before edge releases", int'(s), 1);
      end
    end

    // R4 unknown control code
    seen_req = 1'b0;
    send_cmd(8'h35, 8'h02, 8'h44);
    chk(cmd_hi && !seen_req, "R4 unknown code quiet", int'({cmd_hi, seen_req}), 2);
    stream(8'h34, 8'h00, 1, 0, 4, bad, rel);
    chk(bad == 0 && rel, "R4 next frame decodes", bad, 0);

    // R7 fixed-length reads ignore the address byte
    stream(8'h34, 8'h17, 1, 0, 4, bad, rel);
    chk(bad == 0 && rel, "R7 protection read", bad, 0);
    stream(8'h31, 8'hE2, 2, 0, 4, bad, rel);
    chk(bad == 0 && rel, "R7 code-store read", bad, 0);

    // R5 R6 R13 every start address of the small main array
    for (int n = 0; n < DEPTH; n++) begin
      stream(8'h30, 8'(n), 0, n, DEPTH - n, bad, rel);
      chk(bad == 0, $sformatf("R5 R13 main read from %0d", n), bad, 0);
      chk(rel == 1'b1, $sformatf("R6 release after read from %0d", n), int'(rel), 1);
    end

    // R11 abort during a read, then R12 clocks under reset
    send_cmd(8'h30, 8'd3, 8'h00);
    repeat (5) pulse(1'b1, -1, s);
    card_rst = 1'b1;
    repeat (6) @(negedge clk);
    chk(!io_oe && !fetch_valid, "R11 abort read", int'({io_oe, fetch_valid}), 0);
    repeat (10) pulse(1'b0, -1, s);
    card_rst = 1'b0;
    repeat (6) @(negedge clk);
    stream(8'h31, 8'h00, 2, 0, 4, bad, rel);
    chk(bad == 0 && rel, "R12 clocks under reset ignored", bad, 0);

    // R11 abort with a pending request
    send_cmd(8'h3C, 8'h05, 8'h00);
    chk(op_valid, "R11 request pending before abort", int'(op_valid), 1);
    card_rst = 1'b1;
    repeat (6) @(negedge clk);
    chk(!op_valid && !io_oe, "R11 abort processing", int'({op_valid, io_oe}), 0);
    card_rst = 1'b0;
    repeat (6) @(negedge clk);
    stream(8'h30, 8'd28, 0, 28, 4, bad, rel);
    chk(bad == 0 && rel, "R11 recovery after abort", bad, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule